// File: doc/BRIEF.md
# Stream Packet Framer with Trigger and Control Insertion

This block sits on the transmit side of a camera's high-speed serial image link, directly ahead of the 8b/10b encoder. It accepts 32-bit pixel words from a video source and wraps them into framed stream packets. Each packet has a K-character header word, a programmable number of data words, a CRC-32 word and a K-character trailer word. Two further request ports accept short trigger and control messages. The framer inserts these between video packets by a fixed priority, so that everything shares one output word stream.

Each output word carries four characters. Character 0 sits in bits 7:0 and character 3 in bits 31:24, and each character has its own K flag that tells the encoder to emit a control code for it. When no packet is pending, and when the video source runs dry in the middle of a packet, the framer sends a fixed K-character idle word. This keeps the link aligned. Every port uses a valid/ready handshake, and the output word is registered.

Top module: `pkt_framer`

## Requirements
- R1: While reset is asserted, out_valid and all three input ready signals are low. After reset, with nothing pending, the first output word is the idle word.
- R2: A video packet opens with the header word 0xFBFBFBFB with out_k = 4'hF. Each accepted video word then appears unchanged with out_k = 4'h0, in the order it was accepted.
- R3: pkt_words is sampled when the header is sent, and the packet carries exactly that many data words. A value of zero is treated as one.
- R4: The word after the last data word is the bitwise inverse of a CRC-32 with out_k = 4'h0. The CRC register starts at all ones and uses polynomial 0x04C11DB7. It covers the packet's data bytes in order, from character 0 to character 3 of each word, and takes each byte most significant bit first.
- R5: The word after the CRC word is the trailer word 0xFDFDFDFD with out_k = 4'hF.
- R6: A trigger packet is the marker word 0x7C7C7C7C with out_k = 4'hF, followed by the trigger payload word with out_k = 4'h0.
- R7: A control packet is the marker word 0xDCDCDCDC with out_k = 4'hF, followed by the control payload word with out_k = 4'h0.
- R8: At a packet boundary, a pending trigger is sent before a pending control message, and a pending control message is sent before a new video packet.
- R9: A started video packet is never interrupted by a marker. At most one input ready is high at a time. vid_ready is high only while video data words are being sent.
- R10: The idle word is 0x3C3C3CBC with out_k = 4'hF. It is sent between packets when nothing is pending, and inside a video packet when no video word is available.
- R11: While out_valid is high and out_ready is low, out_data and out_k hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_words | input | LEN_W | Data words per video packet |
| vid_valid | input | 1 | Video word available |
| vid_ready | output | 1 | Video word taken |
| vid_data | input | 32 | Video word, character 0 in bits 7:0 |
| trg_valid | input | 1 | Trigger message pending |
| trg_ready | output | 1 | Trigger message taken |
| trg_data | input | 32 | Trigger payload |
| ctl_valid | input | 1 | Control message pending |
| ctl_ready | output | 1 | Control message taken |
| ctl_data | input | 32 | Control payload |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Four output characters |
| out_k | output | 4 | K flag per character |

## Verification
The bench builds the framer with LEN_W = 4, so the largest packet length, 15 words, can be reached in a short run. The same build also covers the zero-to-one length rule and single-word packets. With this narrow length field, many short packets fit in one run. Trigger and control messages therefore arrive at packet boundaries many times, and also arrive while a packet is in flight. Random out_ready back-pressure and random gaps in the video source exercise the hold rule and the idle fill inside packets.

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int          LEN_W    = 8,
  parameter logic [31:0] CRC_POLY = 32'h04C11DB7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] pkt_words,
  input  logic             vid_valid,
  output logic             vid_ready,
  input  logic [31:0]      vid_data,
  input  logic             trg_valid,
  output logic             trg_ready,
  input  logic [31:0]      trg_data,
  input  logic             ctl_valid,
  output logic             ctl_ready,
  input  logic [31:0]      ctl_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic [3:0]       out_k
);
  localparam logic [31:0] W_HDR = 32'hFBFBFBFB;
  localparam logic [31:0] W_TRL = 32'hFDFDFDFD;
  localparam logic [31:0] W_TRG = 32'h7C7C7C7C;
  localparam logic [31:0] W_CTL = 32'hDCDCDCDC;
  localparam logic [31:0] W_IDL = 32'h3C3C3CBC;
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  typedef enum logic [2:0] {S_ARB, S_DAT, S_CRC, S_TRL, S_PAY} st_t;

  st_t              st_q, st_d;
  logic [LEN_W-1:0] cnt_q;
  logic [31:0]      crc_q, pay_q, od_q, nxt_data;
  logic [3:0]       ok_q, nxt_k;
  logic             ov_q, run_q, load;

  function automatic logic [31:0] crc_word(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 4; b++)
      for (int i = 7; i >= 0; i--)
        r = {r[30:0], 1'b0} ^ ((r[31] ^ d[8*b+i]) ? CRC_POLY : 32'h0);
    return r;
  endfunction

  assign load      = run_q && (!ov_q || out_ready);
  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_k     = ok_q;

  always_comb begin
    nxt_data  = W_IDL;
    nxt_k     = 4'hF;
    st_d      = st_q;
    trg_ready = 1'b0;
    ctl_ready = 1'b0;
    vid_ready = 1'b0;
    case (st_q)
      S_ARB:
        if (trg_valid) begin
          nxt_data = W_TRG; trg_ready = load; st_d = S_PAY;
        end else if (ctl_valid) begin
          nxt_data = W_CTL; ctl_ready = load; st_d = S_PAY;
        end else if (vid_valid) begin
          nxt_data = W_HDR; st_d = S_DAT;
        end
      S_DAT:
        if (vid_valid) begin
          nxt_data = vid_data; nxt_k = 4'h0; vid_ready = load;
          if (cnt_q == ONE) st_d = S_CRC;
        end
      S_CRC: begin nxt_data = ~crc_q; nxt_k = 4'h0; st_d = S_TRL; end
      S_TRL: begin nxt_data = W_TRL; st_d = S_ARB; end
      S_PAY: begin nxt_data = pay_q; nxt_k = 4'h0; st_d = S_ARB; end
      default: st_d = S_ARB;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_ARB;
      cnt_q <= '0;
      crc_q <= '1;
      pay_q <= '0;
      od_q  <= '0;
      ok_q  <= '0;
      ov_q  <= 1'b0;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (load) begin
        ov_q <= 1'b1;
        od_q <= nxt_data;
        ok_q <= nxt_k;
        st_q <= st_d;
        if (trg_ready) pay_q <= trg_data;
        if (ctl_ready) pay_q <= ctl_data;
        if (st_q == S_ARB && !trg_valid && !ctl_valid && vid_valid) begin
          cnt_q <= (pkt_words == '0) ? ONE : pkt_words;
          crc_q <= '1;
        end
        if (vid_ready) begin
          cnt_q <= cnt_q - ONE;
          crc_q <= crc_word(crc_q, vid_data);
        end
      end
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_k)));

  p_one_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trg_ready, ctl_ready, vid_ready}));

  p_vid_only_in_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_DAT) |-> !vid_ready);

  p_trg_before_ctl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trg_valid |-> !ctl_ready);

  p_vid_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vid_ready |=> (out_data == $past(vid_data) && out_k == 4'h0));
endmodule

// File: tb/pkt_framer_bench.sv
module pkt_framer_bench;
  localparam int LEN_W = 4;
  localparam logic [31:0] W_HDR = 32'hFBFBFBFB, W_TRL = 32'hFDFDFDFD,
                          W_TRG = 32'h7C7C7C7C, W_CTL = 32'hDCDCDCDC,
                          W_IDL = 32'h3C3C3CBC;

  logic clk = 0, rst_n = 0;
  logic [LEN_W-1:0] pkt_words = 5;
  logic vid_valid = 0, trg_valid = 0, ctl_valid = 0, out_ready = 0;
  logic [31:0] vid_data = 0, trg_data = 0, ctl_data = 0;
  logic vid_ready, trg_ready, ctl_ready, out_valid;
  logic [31:0] out_data;
  logic [3:0] out_k;

  pkt_framer #(.LEN_W(LEN_W)) u_pkt_framer (
    .clk(clk), .rst_n(rst_n), .pkt_words(pkt_words),
    .vid_valid(vid_valid), .vid_ready(vid_ready), .vid_data(vid_data),
    .trg_valid(trg_valid), .trg_ready(trg_ready), .trg_data(trg_data),
    .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_data(ctl_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_k(out_k));

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  int p_vid = 60, p_trg = 5, p_ctl = 5, p_rdy = 70;
  int vid_left = 0, trg_left = 0, ctl_left = 0;
  int ps = 0, cnt = 0, cur_len = 5;
  logic acc_v = 0, acc_t = 0, acc_c = 0;
  logic held = 0;
  logic [31:0] held_d, crc;
  logic [3:0] held_k;
  logic [31:0] vq[$], tq[$], cq[$];
  byte mlog[$];

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c;
    for (int b = 0; b < 4; b++)
      for (int i = 7; i >= 0; i--)
        r = {r[30:0], 1'b0} ^ ((r[31] ^ d[8*b+i]) ? 32'h04C11DB7 : 32'h0);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic parse(input logic [31:0] d, input logic [3:0] k);
    logic [31:0] e;
    case (ps)
      0: begin
        chk(k == 4'hF, "R10 boundary word K flags", {k, d}, {4'hF, d});
        if (d == W_HDR) begin ps = 1; cnt = 0; crc = '1; mlog.push_back("V"); end
        else if (d == W_TRG) begin ps = 2; mlog.push_back("T"); end
        else if (d == W_CTL) begin ps = 3; mlog.push_back("C"); end
        else chk(d == W_IDL, "R10 idle word", {k, d}, {4'hF, W_IDL});
      end
      1: begin
        if (k == 4'hF && d == W_IDL) chk(1, "R10", 0, 0);
        else if (k == 4'hF) chk(0, "R9 R3 marker inside packet", {k, d}, 36'h0);
        else begin
          e = (vq.size() > 0) ? vq.pop_front() : 32'hX;
          chk(d == e, "R2 video data", {k, d}, {4'h0, e});
          crc = crc_step(crc, d);
          cnt++;
          if (cnt == cur_len) ps = 4;
        end
      end
      4: begin
        chk(k == 4'h0 && d == ~crc, "R3 R4 crc after length", {k, d}, {4'h0, ~crc});
        ps = 5;
      end
      5: begin
        chk(k == 4'hF && d == W_TRL, "R5 trailer", {k, d}, {4'hF, W_TRL});
        ps = 0;
      end
      2: begin
        e = (tq.size() > 0) ? tq.pop_front() : 32'hX;
        chk(k == 4'h0 && d == e, "R6 trigger payload", {k, d}, {4'h0, e});
        ps = 0;
      end
      default: begin
        e = (cq.size() > 0) ? cq.pop_front() : 32'hX;
        chk(k == 4'h0 && d == e, "R7 control payload", {k, d}, {4'h0, e});
        ps = 0;
      end
    endcase
  endtask

  task automatic step();
    @(negedge clk);
    if (acc_v) begin vid_valid = 0; acc_v = 0; vid_left--; end
    if (acc_t) begin trg_valid = 0; acc_t = 0; trg_left--; end
    if (acc_c) begin ctl_valid = 0; acc_c = 0; ctl_left--; end
    out_ready = ($urandom_range(99) < p_rdy);
    if (!vid_valid && vid_left > 0 && $urandom_range(99) < p_vid) begin vid_valid = 1; vid_data = $urandom; end
    if (!trg_valid && trg_left > 0 && $urandom_range(99) < p_trg) begin trg_valid = 1; trg_data = $urandom; end
    if (!ctl_valid && ctl_left > 0 && $urandom_range(99) < p_ctl) begin ctl_valid = 1; ctl_data = $urandom; end
    #1;
    if (held) chk(out_data == held_d && out_k == held_k, "R11 hold under stall", {out_k, out_data}, {held_k, held_d});
    held = out_valid && !out_ready;
    held_d = out_data; held_k = out_k;
    chk($countones({trg_ready, ctl_ready, vid_ready}) <= 1, "R9 single ready", {33'h0, trg_ready, ctl_ready, vid_ready}, 36'h0);
    if (out_valid && out_ready) parse(out_data, out_k);
    if (vid_valid && vid_ready) begin vq.push_back(vid_data); acc_v = 1; end
    if (trg_valid && trg_ready) begin tq.push_back(trg_data); acc_t = 1; end
    if (ctl_valid && ctl_ready) begin cq.push_back(ctl_data); acc_c = 1; end
  endtask

  task automatic run_phase(input int len, input int nv, input int nt, input int nc);
    pkt_words = LEN_W'(len);
    cur_len = (len == 0) ? 1 : len;
    vid_left = nv; trg_left = nt; ctl_left = nc;
    for (int i = 0; i < 20000; i++) begin
      step();
      if (vid_left == 0 && trg_left == 0 && ctl_left == 0 && ps == 0 &&
          vq.size() == 0 && tq.size() == 0 && cq.size() == 0) break;
    end
    chk(ps == 0 && vq.size() == 0, "R3 phase drained", ps, 0);
    for (int i = 0; i < 8; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    chk(!out_valid && !vid_ready && !trg_ready && !ctl_ready, "R1 reset outputs",
        {32'h0, out_valid, vid_ready, trg_ready, ctl_ready}, 36'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid && out_data == W_IDL && out_k == 4'hF, "R1 R10 idle after reset",
        {out_k, out_data}, {4'hF, W_IDL});

    run_phase(5, 60, 10, 10);
    run_phase(1, 20, 6, 6);
    run_phase(0, 20, 4, 4);
    p_rdy = 40; p_vid = 35;
    run_phase(15, 45, 8, 8);

    // R8 directed: trigger and control both pending while a packet is in flight
    p_rdy = 100; p_vid = 100; p_trg = 100; p_ctl = 100;
    pkt_words = 6; cur_len = 6; vid_left = 12;
    for (int i = 0; i < 200 && ps != 1; i++) step();
    mlog.delete();
    run_phase(6, vid_left, 1, 1);
    chk(mlog.size() >= 3 && mlog[0] == "T" && mlog[1] == "C" && mlog[2] == "V",
        "R8 priority order", {mlog.size() > 0 ? mlog[0] : 8'h0, mlog.size() > 1 ? mlog[1] : 8'h0,
        mlog.size() > 2 ? mlog[2] : 8'h0}, {"T", "C", "V"});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule